// File: doc/BRIEF.md
# Four-Mode Barrel Shift Unit

This block is the shift datapath of a 32-bit integer execution stage. It gets the decoded 5-bit opcode, the operand to be shifted, the low five bits of a count register and the five-bit count field of the instruction. From these it forms a 32-bit result in the same cycle. It supports four shift kinds: logical right, arithmetic right, logical left and rotate left. A valid flag tells the surrounding pipeline whether the opcode was a shift at all.

The shift amount comes from the instruction's count field when that field is nonzero. A zero count field makes the unit take the amount from the low five bits of the count register. Software can therefore encode a constant shift or a variable shift with one opcode. The unit is purely combinational and has no clock, reset or handshake. The result and flag follow the inputs within the same cycle, and the caller registers them as it needs. Register file access and writeback belong to the surrounding pipeline.

Top module: `barrel_shift_unit`

## Requirements
- R1: When `imm_count` is nonzero it is the shift amount; when `imm_count` is zero the amount is `reg_count`.
- R2: Opcode 26 (5'b11010) shifts `operand` right by the amount and fills the vacated upper bits with zeros.
- R3: Opcode 27 (5'b11011) shifts `operand` right by the amount and fills the vacated upper bits with copies of `operand[31]`.
- R4: Opcode 28 (5'b11100) shifts `operand` left by the amount and fills the vacated lower bits with zeros.
- R5: Opcode 29 (5'b11101) rotates `operand` left by the amount; bits leaving bit 31 re-enter at bit 0.
- R6: An effective amount of zero (both count inputs zero) returns `operand` unchanged in all four shift opcodes.
- R7: `result_valid` is 1 exactly for opcodes 26 to 29; for every other opcode `result_valid` is 0 and `result` is all zeros.
- R8: An arithmetic right shift by 13 yields 13 copies of the sign bit in bits 31..19 and `operand[31:13]` in bits 18..0.
- R9: `result` and `result_valid` depend only on the present inputs, with no added cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 5 | Decoded instruction opcode |
| operand | input | 32 | Value to be shifted |
| reg_count | input | 5 | Low five bits of the count register |
| imm_count | input | 5 | Count field taken from the instruction |
| result | output | 32 | Shifted value, zero when not a shift opcode |
| result_valid | output | 1 | High when the opcode is one of the four shifts |

## Verification
Immediate assertions inside the shifter check invariants for every input combination. A zero amount leaves the word intact. A rotation keeps the number of one bits. A logical right shift clears the top bit and a left shift clears the bottom bit. An arithmetic shift keeps the sign. A non-shift opcode drives a zero result. The exact bit placement of each mode and the choice between the two count sources can only be shown by the bench, which compares each result with an independent model. The bench does this for random and directed operands, and also covers the shift-by-13 example and the all-zero-count case.

// File: rtl/shift_pkg.sv
package shift_pkg;
  localparam int OPC_W = 5;

  localparam logic [OPC_W-1:0] OPC_SRL = 5'd26;
  localparam logic [OPC_W-1:0] OPC_SRA = 5'd27;
  localparam logic [OPC_W-1:0] OPC_SLL = 5'd28;
  localparam logic [OPC_W-1:0] OPC_ROL = 5'd29;

  typedef enum logic [1:0] {
    MODE_SRL = 2'd0,
    MODE_SRA = 2'd1,
    MODE_SLL = 2'd2,
    MODE_ROL = 2'd3
  } shift_mode_e;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_pkg::*;
(
  input  logic [OPC_W-1:0] op_code,
  output shift_mode_e      mode,
  output logic             is_shift
);
  always_comb begin
    mode     = MODE_SRL;
    is_shift = 1'b1;
    unique case (op_code)
      OPC_SRL: mode = MODE_SRL;
      OPC_SRA: mode = MODE_SRA;
      OPC_SLL: mode = MODE_SLL;
      OPC_ROL: mode = MODE_ROL;
      default: is_shift = 1'b0;
    endcase
  end
endmodule

// File: rtl/shift_count_sel.sv
module shift_count_sel #(
  parameter int CW = 5
) (
  input  logic [CW-1:0] reg_count,
  input  logic [CW-1:0] imm_count,
  output logic [CW-1:0] amount
);
  // A zero instruction field defers to the count register.
  assign amount = (imm_count != '0) ? imm_count : reg_count;
endmodule

// File: rtl/shift_core.sv
module shift_core
  import shift_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  shift_mode_e   mode,
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] amount,
  output logic [W-1:0]  dout
);
  logic go_left;
  logic wrap;
  logic fill_bit;
  logic [W-1:0] stage [0:CW];

  assign go_left  = (mode == MODE_SLL) || (mode == MODE_ROL);
  assign wrap     = (mode == MODE_ROL);
  assign fill_bit = (mode == MODE_SRA) ? din[W-1] : 1'b0;
  assign stage[0] = din;

  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] moved;
    always_comb begin
      if (go_left)
        moved = {stage[k][W-1-S:0], (wrap ? stage[k][W-1:W-S] : {S{1'b0}})};
      else
        moved = {{S{fill_bit}}, stage[k][W-1:S]};
    end
    assign stage[k+1] = amount[k] ? moved : stage[k];
  end

  assign dout = stage[CW];

  always_comb begin
    if (amount == '0)
      assert_zero_amount_identity_R6: assert (dout == din);
    if (mode == MODE_ROL)
      assert_rotate_keeps_ones_R5: assert ($countones(dout) == $countones(din));
    if (mode == MODE_SRL && amount != '0)
      assert_srl_top_clear_R2: assert (dout[W-1] == 1'b0);
    if (mode == MODE_SLL && amount != '0)
      assert_sll_bottom_clear_R4: assert (dout[0] == 1'b0);
    if (mode == MODE_SRA)
      assert_sra_keeps_sign_R3: assert (dout[W-1] == din[W-1]);
  end
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import shift_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic [OPC_W-1:0] op_code,
  input  logic [W-1:0]     operand,
  input  logic [CW-1:0]    reg_count,
  input  logic [CW-1:0]    imm_count,
  output logic [W-1:0]     result,
  output logic             result_valid
);
  shift_mode_e   mode;
  logic          is_shift;
  logic [CW-1:0] amount;
  logic [W-1:0]  shifted;

  shift_decode u_decode (
    .op_code  (op_code),
    .mode     (mode),
    .is_shift (is_shift)
  );

  shift_count_sel #(.CW(CW)) u_count (
    .reg_count (reg_count),
    .imm_count (imm_count),
    .amount    (amount)
  );

  shift_core #(.W(W), .CW(CW)) u_core (
    .mode   (mode),
    .din    (operand),
    .amount (amount),
    .dout   (shifted)
  );

  assign result_valid = is_shift;
  assign result       = is_shift ? shifted : '0;

  always_comb begin
    if (!result_valid)
      assert_idle_result_zero_R7: assert (result == '0);
    if (result_valid && mode == MODE_SRL && imm_count != '0)
      assert_imm_count_used_R1: assert (result == (operand >> imm_count));
  end
endmodule

// File: tb/barrel_shift_unit_bench.sv
module barrel_shift_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op_code = '0;
  logic [31:0] operand = '0;
  logic [4:0]  reg_count = '0;
  logic [4:0]  imm_count = '0;
  logic [31:0] result;
  logic        result_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4ns clk = ~clk;

  barrel_shift_unit u_barrel_shift_unit (
    .op_code      (op_code),
    .operand      (operand),
    .reg_count    (reg_count),
    .imm_count    (imm_count),
    .result       (result),
    .result_valid (result_valid)
  );

  function automatic logic [32:0] model(input logic [4:0] op, input logic [31:0] x,
                                        input logic [4:0] rc, input logic [4:0] ic);
    logic [4:0]  n;
    logic [31:0] y;
    n = (ic != 0) ? ic : rc;
    case (op)
      5'd26: y = x >> n;
      5'd27: y = 32'($signed(x) >>> n);
      5'd28: y = x << n;
      5'd29: y = (n == 0) ? x : ((x << n) | (x >> (6'd32 - {1'b0, n})));
      default: return 33'd0;
    endcase
    return {1'b1, y};
  endfunction

  task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s op=%0d x=%h rc=%0d ic=%0d actual=%h expected=%h",
               tag, op_code, operand, reg_count, imm_count, got, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [4:0] op, input logic [31:0] x,
                       input logic [4:0] rc, input logic [4:0] ic);
    @(posedge clk);
    op_code = op; operand = x; reg_count = rc; imm_count = ic;
    @(negedge clk);
    check(tag, {result_valid, result}, model(op, x, rc, ic));
  endtask

  function automatic string tag_for(input logic [4:0] op);
    case (op)
      5'd26: return "R2";
      5'd27: return "R3";
      5'd28: return "R4";
      5'd29: return "R5";
      default: return "R7";
    endcase
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset-state idle inputs", {result_valid, result}, 33'd0);

    // R1: immediate wins when nonzero, register used when immediate is zero
    apply("R1 imm over reg", 5'd28, 32'h0000_0001, 5'd20, 5'd3);
    check("R1 imm over reg value", {result_valid, result}, {1'b1, 32'h0000_0008});
    apply("R1 reg when imm zero", 5'd28, 32'h0000_0001, 5'd20, 5'd0);
    check("R1 reg when imm zero value", {result_valid, result}, {1'b1, 32'h0010_0000});

    // R2..R5 directed edges
    apply("R2 srl by 31", 5'd26, 32'hFFFF_FFFF, 5'd0, 5'd31);
    check("R2 srl by 31 value", {result_valid, result}, {1'b1, 32'h0000_0001});
    apply("R3 sra negative by 31", 5'd27, 32'h8000_0000, 5'd31, 5'd0);
    check("R3 sra value", {result_valid, result}, {1'b1, 32'hFFFF_FFFF});
    apply("R4 sll by 31", 5'd28, 32'hFFFF_FFFF, 5'd0, 5'd31);
    check("R4 sll value", {result_valid, result}, {1'b1, 32'h8000_0000});
    apply("R5 rotate wrap", 5'd29, 32'h8000_0001, 5'd0, 5'd1);
    check("R5 rotate value", {result_valid, result}, {1'b1, 32'h0000_0003});

    // R8: sra by 13
    apply("R8 sra 13 negative", 5'd27, 32'hA5A5_1234, 5'd0, 5'd13);
    check("R8 sra 13 value", {result_valid, result}, {1'b1, {13{1'b1}}, 19'(32'hA5A5_1234 >> 13)});
    apply("R8 sra 13 positive", 5'd27, 32'h5A5A_1234, 5'd7, 5'd13);

    // R6: zero effective count in every mode
    for (int op = 26; op <= 29; op++) begin
      apply("R6 zero count", 5'(op), 32'hDEAD_BEEF, 5'd0, 5'd0);
      check("R6 zero count identity", {result_valid, result}, {1'b1, 32'hDEAD_BEEF});
    end

    // R7: non-shift opcodes
    apply("R7 opcode 0", 5'd0, 32'hFFFF_FFFF, 5'd4, 5'd4);
    apply("R7 opcode 25", 5'd25, 32'h1234_5678, 5'd1, 5'd1);
    apply("R7 opcode 30", 5'd30, 32'h1234_5678, 5'd1, 5'd1);
    apply("R7 opcode 31", 5'd31, 32'hFFFF_FFFF, 5'd0, 5'd0);

    // R9: input changes without any clock edge show at once
    op_code = 5'd28; operand = 32'h1; reg_count = 5'd0; imm_count = 5'd4;
    #1ns;
    check("R9 same-cycle response", {result_valid, result}, {1'b1, 32'h10});

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [4:0]  op;
      logic [31:0] x;
      logic [4:0]  rc;
      logic [4:0]  ic;
      op = ($urandom % 8 < 6) ? 5'(26 + $urandom % 4) : 5'($urandom);
      x  = $urandom;
      rc = 5'($urandom);
      ic = ($urandom % 3 == 0) ? 5'd0 : 5'($urandom);
      apply(tag_for(op), op, x, rc, ic);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule